// File: doc/BRIEF.md
# Command Ring Enqueue Controller

This block sits in front of a codec command ring. It takes 32-bit command words over a valid/ready handshake and writes each one into a 256-entry circular ring held in local storage. It also keeps the ring write pointer. Before it accepts a command, it checks the advanced write pointer against the read pointer that the downstream consumer publishes. A command that would make the two equal is refused with a retry status, because that case means the ring is full. When the unit is marked powered down, the write pointer reads as all ones and every command fails with an I/O error.

The block also keeps one outstanding-response counter per codec. It takes the codec from the top nibble of each accepted command; an address beyond the supported codec count is folded onto codec 0. The counter goes up when a command is accepted and down when a response is retired, and it saturates with a sticky overflow flag. A small sequencer runs the two-phase read-pointer reset:
- It raises the reset bit and waits for the consumer to acknowledge it.
- It drops the bit and waits for the pointer to read zero.

Each wait is bounded, and a timeout raises a flag and lets the sequence go on. Starting the sequence also returns the write pointer to zero.

Top module: `cmd_ring_enq`

## Requirements
- R1: After reset the write pointer is 0, no status is pending, the reset bit and busy are low, and every outstanding counter and overflow flag is 0.
- R2: An accepted command is stored at ring index wp+1 (mod 256) and the write pointer becomes wp+1. One cycle after the handshake, st_valid pulses with st_code 0 (accepted).
- R3: If wp+1 (mod 256) equals rp_in, the command is refused with st_code 1 (retry). The write pointer, the ring contents and the counters are left unchanged.
- R4: While link_off is high, wr_ptr reads 16'hFFFF and any command ends with st_code 2 (I/O error). Nothing is written and no counter changes.
- R5: While run_en is low, cmd_ready is low and no command is taken, so no status appears.
- R6: The codec address is cmd_data[31:28]. An address at or above NUM_CODECS (4) counts as codec 0. An accepted command increments that codec's counter (pend_cnt[4c+3:4c]) and sets last_cmd[32c+31:32c] to the command.
- R7: A retire pulse (rsp_valid with rsp_codec) decrements that codec's counter but never below 0. A retire and an accept for the same codec in the same cycle leave the counter unchanged.
- R8: A counter at its maximum (15) stays there on a further accept and sets that codec's pend_ovf bit. The bit stays set until reset.
- R9: A pulse on rp_rst_start clears the write pointer to 0 and holds rp_rst_bit high until rp_rst_ack is seen. The block then holds rp_rst_bit low until rp_in is 0 and the acknowledge has dropped. rp_rst_busy is high for the whole sequence and cmd_ready is low.
- R10: Each wait phase lasts at most POLL_LIMIT (1000) cycles. On expiry, the set phase raises rp_tmo_set and the clear phase raises rp_tmo_clr, and the sequence moves on. Both flags clear at the next start.
- R11: The write pointer wraps from 255 to 0, and the command after the wrap is stored at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Ring run enable |
| link_off | input | 1 | Unit powered down; pointer reads all ones |
| cmd_valid | input | 1 | Command offered |
| cmd_data | input | 32 | Command word; bits 31:28 carry the codec address |
| cmd_ready | output | 1 | Command can be taken this cycle |
| st_valid | output | 1 | Status pulse, one cycle after a handshake |
| st_code | output | 2 | 0 accepted, 1 retry (full), 2 I/O error |
| wr_ptr | output | 16 | Write-pointer register view |
| rp_in | input | 8 | Read pointer published by the consumer |
| rp_rst_ack | input | 1 | Consumer reads the reset bit back as set |
| rp_rst_start | input | 1 | Pulse that starts the read-pointer reset |
| rp_rst_bit | output | 1 | Reset bit written to the read pointer |
| rp_rst_busy | output | 1 | Reset sequence in progress |
| rp_tmo_set | output | 1 | Set phase timed out |
| rp_tmo_clr | output | 1 | Clear phase timed out |
| ring_raddr | input | 8 | Ring read index for the consumer |
| ring_rdata | output | 32 | Ring entry at ring_raddr |
| rsp_valid | input | 1 | A response was retired |
| rsp_codec | input | 2 | Codec of the retired response |
| pend_cnt | output | 16 | Outstanding counters, 4 bits per codec |
| pend_ovf | output | 4 | Sticky saturation flag per codec |
| last_cmd | output | 128 | Last command per codec, 32 bits each |

## Verification
The assertions assume that rp_in changes only by the consumer's own rules, so it is never moved past the write pointer in a way the ring could not produce. They also assume that rp_rst_start is pulsed only while no reset sequence is running. The stimulus keeps within these limits in three ways:
- It sets rp_in only between commands.
- It starts a reset only after rp_rst_busy is seen low.
- It drops cmd_valid after every handshake, so each status pulse belongs to exactly one command.

// File: rtl/cmd_ring_pkg.sv
`timescale 1ns/1ps
package cmd_ring_pkg;
    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_RETRY = 2'd1,
        ST_IOERR = 2'd2
    } enq_status_e;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_SET_WAIT,
        RS_CLR_WAIT
    } rp_rst_state_e;
endpackage

// File: rtl/cmd_ring_wptr.sv
`timescale 1ns/1ps
module cmd_ring_wptr
    import cmd_ring_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             init_clr,
    input  logic             link_off,
    input  logic [PTR_W-1:0] rp_in,
    output logic [PTR_W-1:0] wp,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic             st_valid,
    output enq_status_e      st_code
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic             st_valid;
        enq_status_e      st_code;
    } wptr_state_t;

    wptr_state_t s_d, s_q;
    logic [PTR_W-1:0] nxt_wp;
    logic             full;

    always_comb begin
        nxt_wp = s_q.wp + 1'b1;
        full   = (nxt_wp == rp_in);
        wr_en  = 1'b0;
        s_d    = s_q;
        s_d.st_valid = 1'b0;
        if (init_clr) begin
            s_d.wp = '0;
        end else if (fire) begin
            s_d.st_valid = 1'b1;
            if (link_off) begin
                s_d.st_code = ST_IOERR;
            end else if (full) begin
                s_d.st_code = ST_RETRY;
            end else begin
                s_d.st_code = ST_OK;
                s_d.wp      = nxt_wp;
                wr_en       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{wp: '0, st_valid: 1'b0, st_code: ST_OK};
        end else begin
            s_q <= s_d;
        end
    end

    assign wp       = s_q.wp;
    assign wr_idx   = nxt_wp;
    assign st_valid = s_q.st_valid;
    assign st_code  = s_q.st_code;
endmodule

// File: rtl/cmd_ring_store.sv
`timescale 1ns/1ps
module cmd_ring_store #(
    parameter int PTR_W = 8,
    parameter int CMD_W = 32
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [CMD_W-1:0] wr_data,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [CMD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << PTR_W;

    logic [CMD_W-1:0] ring_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ring_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = ring_q[rd_idx];
endmodule

// File: rtl/cmd_ring_rp_reset.sv
`timescale 1ns/1ps
module cmd_ring_rp_reset
    import cmd_ring_pkg::*;
#(
    parameter int PTR_W      = 8,
    parameter int POLL_LIMIT = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ack,
    input  logic [PTR_W-1:0] rp_in,
    output logic             rst_bit,
    output logic             busy,
    output logic             tmo_set,
    output logic             tmo_clr
);
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);

    typedef struct packed {
        rp_rst_state_e     st;
        logic [POLL_W-1:0] cnt;
        logic              tmo_set;
        logic              tmo_clr;
    } rprst_state_t;

    rprst_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            RS_IDLE: begin
                if (start) begin
                    s_d.st      = RS_SET_WAIT;
                    s_d.cnt     = '0;
                    s_d.tmo_set = 1'b0;
                    s_d.tmo_clr = 1'b0;
                end
            end
            RS_SET_WAIT: begin
                if (ack) begin
                    s_d.st  = RS_CLR_WAIT;
                    s_d.cnt = '0;
                end else if (s_q.cnt == POLL_LAST) begin
                    s_d.st      = RS_CLR_WAIT;
                    s_d.cnt     = '0;
                    s_d.tmo_set = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            RS_CLR_WAIT: begin
                if ((rp_in == '0) && !ack) begin
                    s_d.st = RS_IDLE;
                end else if (s_q.cnt == POLL_LAST) begin
                    s_d.st      = RS_IDLE;
                    s_d.tmo_clr = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: RS_IDLE, cnt: '0, tmo_set: 1'b0, tmo_clr: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rst_bit = (s_q.st == RS_SET_WAIT);
    assign busy    = (s_q.st != RS_IDLE);
    assign tmo_set = s_q.tmo_set;
    assign tmo_clr = s_q.tmo_clr;
endmodule

// File: rtl/cmd_ring_pending.sv
`timescale 1ns/1ps
module cmd_ring_pending #(
    parameter int NUM_CODECS = 4,
    parameter int CODEC_W    = 2,
    parameter int CNT_W      = 4,
    parameter int CMD_W      = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        inc_en,
    input  logic [CMD_W-1:0]            cmd_word,
    input  logic                        dec_en,
    input  logic [CODEC_W-1:0]          dec_codec,
    output logic [NUM_CODECS*CNT_W-1:0] cnt_flat,
    output logic [NUM_CODECS-1:0]       ovf,
    output logic [NUM_CODECS*CMD_W-1:0] last_flat
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [3:0]         addr_nib;
    logic [CODEC_W-1:0] inc_codec;

    always_comb begin
        addr_nib = cmd_word[CMD_W-1 -: 4];
        if (32'(addr_nib) < NUM_CODECS) begin
            inc_codec = CODEC_W'(addr_nib);
        end else begin
            inc_codec = '0;
        end
    end

    for (genvar c = 0; c < NUM_CODECS; c++) begin : g_codec
        typedef struct packed {
            logic [CNT_W-1:0] cnt;
            logic             ovf;
            logic [CMD_W-1:0] last;
        } pend_state_t;

        pend_state_t s_d, s_q;
        logic inc_hit, dec_hit;

        always_comb begin
            inc_hit = inc_en && (inc_codec == CODEC_W'(c));
            dec_hit = dec_en && (dec_codec == CODEC_W'(c));
            s_d = s_q;
            if (inc_hit) begin
                s_d.last = cmd_word;
            end
            if (inc_hit && !dec_hit) begin
                if (s_q.cnt == CNT_MAX) begin
                    s_d.ovf = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end else if (dec_hit && !inc_hit) begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s_q <= '0;
            end else begin
                s_q <= s_d;
            end
        end

        assign cnt_flat[c*CNT_W +: CNT_W]  = s_q.cnt;
        assign ovf[c]                      = s_q.ovf;
        assign last_flat[c*CMD_W +: CMD_W] = s_q.last;
    end
endmodule

// File: rtl/cmd_ring_enq.sv
`timescale 1ns/1ps
module cmd_ring_enq
    import cmd_ring_pkg::*;
#(
    parameter int PTR_W      = 8,
    parameter int CMD_W      = 32,
    parameter int VIEW_W     = 16,
    parameter int NUM_CODECS = 4,
    parameter int CODEC_W    = $clog2(NUM_CODECS),
    parameter int CNT_W      = 4,
    parameter int POLL_LIMIT = 1000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run_en,
    input  logic                        link_off,
    input  logic                        cmd_valid,
    input  logic [CMD_W-1:0]            cmd_data,
    output logic                        cmd_ready,
    output logic                        st_valid,
    output logic [1:0]                  st_code,
    output logic [VIEW_W-1:0]           wr_ptr,
    input  logic [PTR_W-1:0]            rp_in,
    input  logic                        rp_rst_ack,
    input  logic                        rp_rst_start,
    output logic                        rp_rst_bit,
    output logic                        rp_rst_busy,
    output logic                        rp_tmo_set,
    output logic                        rp_tmo_clr,
    input  logic [PTR_W-1:0]            ring_raddr,
    output logic [CMD_W-1:0]            ring_rdata,
    input  logic                        rsp_valid,
    input  logic [CODEC_W-1:0]          rsp_codec,
    output logic [NUM_CODECS*CNT_W-1:0] pend_cnt,
    output logic [NUM_CODECS-1:0]       pend_ovf,
    output logic [NUM_CODECS*CMD_W-1:0] last_cmd
);
    logic             fire;
    logic             init_clr;
    logic [PTR_W-1:0] wp;
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    enq_status_e      st_code_e;

    assign init_clr  = rp_rst_start && !rp_rst_busy;
    assign cmd_ready = run_en && !rp_rst_busy && !init_clr;
    assign fire      = cmd_valid && cmd_ready;

    cmd_ring_wptr #(.PTR_W(PTR_W)) u_wptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .init_clr (init_clr),
        .link_off (link_off),
        .rp_in    (rp_in),
        .wp       (wp),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .st_valid (st_valid),
        .st_code  (st_code_e)
    );

    assign st_code = st_code_e;
    assign wr_ptr  = link_off ? '1 : VIEW_W'(wp);

    cmd_ring_store #(.PTR_W(PTR_W), .CMD_W(CMD_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (cmd_data),
        .rd_idx  (ring_raddr),
        .rd_data (ring_rdata)
    );

    cmd_ring_rp_reset #(.PTR_W(PTR_W), .POLL_LIMIT(POLL_LIMIT)) u_rprst (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (init_clr),
        .ack     (rp_rst_ack),
        .rp_in   (rp_in),
        .rst_bit (rp_rst_bit),
        .busy    (rp_rst_busy),
        .tmo_set (rp_tmo_set),
        .tmo_clr (rp_tmo_clr)
    );

    cmd_ring_pending #(
        .NUM_CODECS (NUM_CODECS),
        .CODEC_W    (CODEC_W),
        .CNT_W      (CNT_W),
        .CMD_W      (CMD_W)
    ) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_en    (wr_en),
        .cmd_word  (cmd_data),
        .dec_en    (rsp_valid),
        .dec_codec (rsp_codec),
        .cnt_flat  (pend_cnt),
        .ovf       (pend_ovf),
        .last_flat (last_cmd)
    );
endmodule

// File: rtl/cmd_ring_enq_chk.sv
`timescale 1ns/1ps
module cmd_ring_enq_chk #(
    parameter int PTR_W      = 8,
    parameter int NUM_CODECS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  run_en,
    input logic                  cmd_ready,
    input logic                  st_valid,
    input logic [1:0]            st_code,
    input logic [PTR_W-1:0]      wp,
    input logic                  rp_rst_busy,
    input logic                  rp_rst_bit,
    input logic [NUM_CODECS-1:0] pend_ovf
);
    // R2
    ok_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_code == 2'd0) |-> (wp == PTR_W'($past(wp) + 1'b1)));

    // R3
    refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_code != 2'd0) |-> (wp == $past(wp)));

    // R5
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_en) |-> !st_valid);

    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rp_rst_busy |-> !cmd_ready);

    // R9
    bit_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rp_rst_bit |-> rp_rst_busy);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend_ovf) & ~pend_ovf) == '0));
endmodule

bind cmd_ring_enq cmd_ring_enq_chk #(.PTR_W(PTR_W), .NUM_CODECS(NUM_CODECS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .cmd_ready   (cmd_ready),
    .st_valid    (st_valid),
    .st_code     (st_code),
    .wp          (wp),
    .rp_rst_busy (rp_rst_busy),
    .rp_rst_bit  (rp_rst_bit),
    .pend_ovf    (pend_ovf)
);

// File: tb/cmd_ring_enq_test.sv
`timescale 1ns/1ps
module cmd_ring_enq_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_en = 1'b0;
    logic         link_off = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [31:0]  cmd_data = '0;
    logic         cmd_ready;
    logic         st_valid;
    logic [1:0]   st_code;
    logic [15:0]  wr_ptr;
    logic [7:0]   rp_in = '0;
    logic         rp_rst_ack = 1'b0;
    logic         rp_rst_start = 1'b0;
    logic         rp_rst_bit, rp_rst_busy, rp_tmo_set, rp_tmo_clr;
    logic [7:0]   ring_raddr = '0;
    logic [31:0]  ring_rdata;
    logic         rsp_valid = 1'b0;
    logic [1:0]   rsp_codec = '0;
    logic [15:0]  pend_cnt;
    logic [3:0]   pend_ovf;
    logic [127:0] last_cmd;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cmd_ring_enq uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .link_off(link_off),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .st_valid(st_valid), .st_code(st_code), .wr_ptr(wr_ptr),
        .rp_in(rp_in), .rp_rst_ack(rp_rst_ack), .rp_rst_start(rp_rst_start),
        .rp_rst_bit(rp_rst_bit), .rp_rst_busy(rp_rst_busy),
        .rp_tmo_set(rp_tmo_set), .rp_tmo_clr(rp_tmo_clr),
        .ring_raddr(ring_raddr), .ring_rdata(ring_rdata),
        .rsp_valid(rsp_valid), .rsp_codec(rsp_codec),
        .pend_cnt(pend_cnt), .pend_ovf(pend_ovf), .last_cmd(last_cmd)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; run_en = 1'b1; link_off = 1'b0; cmd_valid = 1'b0;
        rp_in = '0; rp_rst_ack = 1'b0; rp_rst_start = 1'b0; rsp_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input logic [31:0] d, input logic [1:0] exp, input string req);
        cmd_valid = 1'b1; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(st_valid && st_code == exp, req, {29'd0, st_valid, st_code}, {30'd1, exp});
    endtask

    function automatic logic [3:0] cnt_of(input int c);
        return pend_cnt[c*4 +: 4];
    endfunction

    task automatic t_reset_state();
        do_reset();
        chk(wr_ptr == 16'h0 && !st_valid && !rp_rst_bit && !rp_rst_busy, "R1 idle",
            {wr_ptr, 13'd0, st_valid, rp_rst_bit, rp_rst_busy}, 32'h0);
        chk(pend_cnt == '0 && pend_ovf == '0, "R1 counters", {pend_cnt, 12'd0, pend_ovf}, 32'h0);
    endtask

    task automatic t_accept();
        do_reset();
        send(32'h1000_00A1, 2'd0, "R2 first");
        chk(wr_ptr == 16'd1, "R2 wp", {16'd0, wr_ptr}, 32'd1);
        send(32'h2000_00B2, 2'd0, "R2 second");
        send(32'h0000_00C3, 2'd0, "R2 third");
        chk(wr_ptr == 16'd3, "R2 wp3", {16'd0, wr_ptr}, 32'd3);
        ring_raddr = 8'd1; #0.1;
        chk(ring_rdata == 32'h1000_00A1, "R2 idx1", ring_rdata, 32'h1000_00A1);
        ring_raddr = 8'd3; #0.1;
        chk(ring_rdata == 32'h0000_00C3, "R2 idx3", ring_rdata, 32'h0000_00C3);
        @(negedge clk);
        chk(!st_valid, "R2 single pulse", {31'd0, st_valid}, 32'd0);
    endtask

    task automatic t_full();
        do_reset();
        send(32'h1111_1111, 2'd0, "R3 prep");
        rp_in = 8'd2;
        send(32'h1222_2222, 2'd1, "R3 retry");
        chk(wr_ptr == 16'd1, "R3 wp held", {16'd0, wr_ptr}, 32'd1);
        ring_raddr = 8'd2; #0.1;
        chk(ring_rdata !== 32'h1222_2222, "R3 not stored", ring_rdata, 32'h0);
        chk(cnt_of(1) == 4'd1, "R3 count held", {28'd0, cnt_of(1)}, 32'd1);
    endtask

    task automatic t_link_off();
        do_reset();
        send(32'h2000_0001, 2'd0, "R4 prep");
        link_off = 1'b1;
        #0.1;
        chk(wr_ptr == 16'hFFFF, "R4 view", {16'd0, wr_ptr}, 32'hFFFF);
        send(32'h2000_0002, 2'd2, "R4 ioerr");
        link_off = 1'b0;
        #0.1;
        chk(wr_ptr == 16'd1 && cnt_of(2) == 4'd1, "R4 nothing changed",
            {wr_ptr, 12'd0, cnt_of(2)}, {16'd1, 16'd1});
    endtask

    task automatic t_stopped();
        do_reset();
        run_en = 1'b0;
        cmd_valid = 1'b1; cmd_data = 32'h3000_0003;
        #0.1;
        chk(!cmd_ready, "R5 ready low", {31'd0, cmd_ready}, 32'd0);
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        chk(!st_valid && wr_ptr == 16'd0 && cnt_of(3) == 4'd0, "R5 no effect",
            {wr_ptr, 11'd0, st_valid, cnt_of(3)}, 32'd0);
        run_en = 1'b1;
    endtask

    task automatic t_codec_map();
        do_reset();
        send(32'h9ABC_DEF0, 2'd0, "R6 high addr");
        chk(cnt_of(0) == 4'd1 && last_cmd[31:0] == 32'h9ABC_DEF0, "R6 folded to 0",
            last_cmd[31:0], 32'h9ABC_DEF0);
        send(32'h2000_0011, 2'd0, "R6 codec2");
        chk(cnt_of(2) == 4'd1 && last_cmd[95:64] == 32'h2000_0011, "R6 codec2 rec",
            last_cmd[95:64], 32'h2000_0011);
    endtask

    task automatic t_retire();
        do_reset();
        send(32'h2000_0011, 2'd0, "R7 prep");
        rsp_valid = 1'b1; rsp_codec = 2'd2;
        @(negedge clk);
        chk(cnt_of(2) == 4'd0, "R7 dec", {28'd0, cnt_of(2)}, 32'd0);
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(cnt_of(2) == 4'd0, "R7 floor", {28'd0, cnt_of(2)}, 32'd0);
        send(32'h2000_0022, 2'd0, "R7 prep2");
        rsp_valid = 1'b1; rsp_codec = 2'd2;
        send(32'h2000_0033, 2'd0, "R7 both");
        rsp_valid = 1'b0;
        chk(cnt_of(2) == 4'd1 && last_cmd[95:64] == 32'h2000_0033, "R7 both same",
            {28'd0, cnt_of(2)}, 32'd1);
    endtask

    task automatic t_saturate();
        do_reset();
        for (int i = 0; i < 15; i++) send(32'h1000_0000 | i, 2'd0, "R8 fill");
        chk(cnt_of(1) == 4'd15 && !pend_ovf[1], "R8 at max", {27'd0, pend_ovf[1], cnt_of(1)}, 32'h0F);
        send(32'h1000_00FF, 2'd0, "R8 extra");
        chk(cnt_of(1) == 4'd15 && pend_ovf[1], "R8 saturated", {27'd0, pend_ovf[1], cnt_of(1)}, 32'h1F);
        rsp_valid = 1'b1; rsp_codec = 2'd1;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(cnt_of(1) == 4'd14 && pend_ovf[1], "R8 sticky", {27'd0, pend_ovf[1], cnt_of(1)}, 32'h1E);
    endtask

    task automatic t_rp_reset();
        do_reset();
        send(32'h0000_0001, 2'd0, "R9 prep");
        rp_in = 8'd7;
        rp_rst_start = 1'b1;
        @(negedge clk);
        rp_rst_start = 1'b0;
        chk(rp_rst_bit && rp_rst_busy && wr_ptr == 16'd0 && !cmd_ready, "R9 set phase",
            {wr_ptr, 13'd0, rp_rst_bit, rp_rst_busy, cmd_ready}, 32'h6);
        repeat (3) @(negedge clk);
        chk(rp_rst_bit, "R9 waits ack", {31'd0, rp_rst_bit}, 32'd1);
        rp_rst_ack = 1'b1;
        @(negedge clk);
        rp_rst_ack = 1'b0;
        chk(!rp_rst_bit && rp_rst_busy, "R9 clear phase", {30'd0, rp_rst_bit, rp_rst_busy}, 32'd1);
        repeat (2) @(negedge clk);
        chk(rp_rst_busy, "R9 waits zero", {31'd0, rp_rst_busy}, 32'd1);
        rp_in = 8'd0;
        @(negedge clk);
        chk(!rp_rst_busy && !rp_tmo_set && !rp_tmo_clr && cmd_ready, "R9 done",
            {28'd0, rp_rst_busy, rp_tmo_set, rp_tmo_clr, cmd_ready}, 32'd1);
    endtask

    task automatic t_timeout();
        do_reset();
        rp_in = 8'd7;
        rp_rst_start = 1'b1;
        @(negedge clk);
        rp_rst_start = 1'b0;
        repeat (995) @(negedge clk);
        chk(rp_rst_bit && !rp_tmo_set, "R10 still polling", {30'd0, rp_rst_bit, rp_tmo_set}, 32'd2);
        repeat (10) @(negedge clk);
        chk(!rp_rst_bit && rp_tmo_set && rp_rst_busy, "R10 set timeout",
            {29'd0, rp_rst_bit, rp_tmo_set, rp_rst_busy}, 32'd3);
        repeat (1000) @(negedge clk);
        chk(!rp_rst_busy && rp_tmo_clr, "R10 clear timeout",
            {30'd0, rp_rst_busy, rp_tmo_clr}, 32'd1);
        rp_in = 8'd0;
        rp_rst_start = 1'b1;
        @(negedge clk);
        rp_rst_start = 1'b0;
        chk(!rp_tmo_set && !rp_tmo_clr, "R10 flags cleared", {30'd0, rp_tmo_set, rp_tmo_clr}, 32'd0);
        rp_rst_ack = 1'b1;
        @(negedge clk);
        rp_rst_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_wrap();
        do_reset();
        rp_in = 8'd250;
        for (int i = 0; i < 200; i++) send(32'h3000_0000 | i, 2'd0, "R11 batch1");
        rp_in = 8'd100;
        for (int j = 1; j <= 60; j++) send(32'h3100_0000 | j, 2'd0, "R11 batch2");
        chk(wr_ptr == 16'd4, "R11 wrapped wp", {16'd0, wr_ptr}, 32'd4);
        ring_raddr = 8'd0; #0.1;
        chk(ring_rdata == 32'h3100_0038, "R11 index0", ring_rdata, 32'h3100_0038);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_accept();
        t_full();
        t_link_off();
        t_stopped();
        t_codec_map();
        t_retire();
        t_saturate();
        t_rp_reset();
        t_timeout();
        t_wrap();
        finished = 1'b1;
        report();
        $finish;
    end
endmodule